// File: doc/BRIEF.md
# Flash Write-Status Response Generator

This block reproduces the way a parallel NOR-style flash answers reads while an internal program or erase runs. The host issues write strobes, each with an operation code and a data byte. Once enough strobes of a sequence have arrived, the block marks itself busy for a fixed number of clock cycles. That count stands in for the internal write time, and each operation kind has its own count.

While busy, every read returns a status byte instead of array contents. Bit 7 is a polling bit: for a program it is the complement of bit 7 of the byte being written, and for an erase it is zero. Bit 6 flips on every read, and the first read of an operation returns 1. Bits 5 to 0 are zero. Strobes that arrive while busy are dropped and count toward nothing.

Once the timer runs out, reads pass the array data through unchanged. The sequence decoder only counts strobes. It does not check command values, and the array itself sits outside the block.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `busy` is 0, `rd_data` is 8'h00 and no strobes are counted.
- R2: With `cmd_op` = 2'b00 (program), `busy` rises in the cycle after the 4th accepted strobe and stays 0 after the 1st to 3rd.
- R3: With `cmd_op` = 2'b01 (sector erase) or 2'b1x (chip erase), `busy` rises in the cycle after the 6th accepted strobe and stays 0 after the 1st to 5th.
- R4: `busy` stays high for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES clock cycles, selected by the operation code of the final strobe.
- R5: During a program, a read returns bit 7 equal to the inverse of bit 7 of `cmd_data` on the final strobe.
- R6: During a sector or chip erase, a read returns bit 7 equal to 0.
- R7: During any operation, bit 6 of successive reads alternates, and the first read after the operation starts returns 1.
- R8: During any operation, bits 5..0 of a read are 0.
- R9: When not busy, a read returns `array_data` as sampled at the read edge, on `rd_data` from the following cycle.
- R10: Strobes received while `busy` is high are ignored: they neither extend the operation nor count toward the next sequence.
- R11: `rd_data` holds its value in any cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe, one cycle per bus write |
| cmd_op | input | 2 | Operation of the current sequence: 00 program, 01 sector erase, 1x chip erase |
| cmd_data | input | 8 | Data byte of the strobe; on the final program strobe, the byte being written |
| rd_en | input | 1 | Read strobe |
| array_data | input | 8 | True array contents at the read address |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | Internal operation in progress |

## Verification
The bench sweeps every operation kind against data bytes with bit 7 both set and clear. It reads on an irregular pattern so that toggle parity is checked across skipped cycles. A design that started the toggle at 0 or kept its phase from the previous operation would show a 0 on the first status read. A design that leaked the inverted bit into erases, or ran a timer one cycle off, would show up in bit 7 or in the measured busy length. Strobes are injected throughout each busy window. If they were counted, the next sequence would launch early or the busy window would stretch, and the strobe-by-strobe busy checks catch that.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int PROG_CYCLES = 20,
  parameter int SECT_CYCLES = 60,
  parameter int CHIP_CYCLES = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       rd_en,
  input  logic [7:0] array_data,
  output logic [7:0] rd_data,
  output logic       busy
);
  localparam int MAXC = (PROG_CYCLES > SECT_CYCLES) ?
                        ((PROG_CYCLES > CHIP_CYCLES) ? PROG_CYCLES : CHIP_CYCLES) :
                        ((SECT_CYCLES > CHIP_CYCLES) ? SECT_CYCLES : CHIP_CYCLES);
  localparam int TW = $clog2(MAXC + 1);

  logic [2:0]    wcnt;
  logic [TW-1:0] timer;
  logic          erase_q, wbit7_q, tog_q;
  logic [2:0]    need;
  logic [TW-1:0] dur;
  logic          accept, launch;

  assign need   = (cmd_op == 2'b00) ? 3'd4 : 3'd6;
  assign dur    = (cmd_op == 2'b00) ? TW'(PROG_CYCLES) :
                  (cmd_op == 2'b01) ? TW'(SECT_CYCLES) : TW'(CHIP_CYCLES);
  assign accept = cmd_wr && !busy;
  assign launch = accept && (wcnt + 3'd1 == need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt    <= '0;
      busy    <= 1'b0;
      timer   <= '0;
      erase_q <= 1'b0;
      wbit7_q <= 1'b0;
    end else if (launch) begin
      wcnt    <= '0;
      busy    <= 1'b1;
      timer   <= dur;
      erase_q <= (cmd_op != 2'b00);
      wbit7_q <= cmd_data[7];
    end else if (accept) begin
      wcnt <= wcnt + 3'd1;
    end else if (busy) begin
      if (timer == TW'(1)) busy <= 1'b0;
      timer <= timer - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      tog_q   <= 1'b1;
    end else if (launch) begin
      tog_q <= 1'b1;
    end else if (rd_en) begin
      if (busy) begin
        rd_data <= {erase_q ? 1'b0 : ~wbit7_q, tog_q, 6'b0};
        tog_q   <= ~tog_q;
      end else begin
        rd_data <= array_data;
      end
    end
  end
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic [7:0] array_data,
  input logic [2:0] wcnt,
  input logic       erase_q
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) seen <= 1'b0;
    else if (rd_en)      seen <= 1'b1;
  end

  p_low_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rd_data[5:0] == 6'b0));
  p_erase_poll_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && erase_q) |=> !rd_data[7]);
  p_toggle_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && !seen) |=> rd_data[6]);
  p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && seen) |=> (rd_data[6] != $past(rd_data[6])));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_en) |=> (rd_data == $past(array_data)));
  p_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wcnt == 3'd0));
endmodule

bind flash_status_gen flash_status_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en), .rd_data(rd_data),
  .array_data(array_data), .wcnt(wcnt), .erase_q(erase_q)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
  localparam int PC = 5, SC = 9, CC = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, rd_en = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00, array_data = 8'h00;
  logic [7:0] rd_data;
  logic busy;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_status_gen #(.PROG_CYCLES(PC), .SECT_CYCLES(SC), .CHIP_CYCLES(CC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rd_en(rd_en), .array_data(array_data), .rd_data(rd_data), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] data);
    int need, dur, cyc, k;
    logic [7:0] prev, exp;
    need = (op == 2'b00) ? 4 : 6;
    dur  = (op == 2'b00) ? PC : (op == 2'b01) ? SC : CC;
    for (int i = 0; i < need; i++) begin
      cmd_wr = 1'b1; cmd_op = op; cmd_data = (i == need - 1) ? data : 8'h55;
      step();
      cmd_wr = 1'b0;
      if (i < need - 1) check("R2/R3/R10 idle before last strobe", busy, 0);
      else              check("R2/R3 busy after last strobe", busy, 1);
    end
    cyc = 0; k = 0; prev = rd_data;
    while (busy && cyc < 100) begin
      rd_en = (cyc % 3 != 2);
      cmd_wr = (cyc % 4 == 1); cmd_op = 2'b00; cmd_data = 8'hFF;
      array_data = 8'(cyc * 37 + 11);
      step();
      cmd_wr = 1'b0;
      if (rd_en) begin
        exp = {(op == 2'b00) ? ~data[7] : 1'b0, (k % 2 == 0), 6'b0};
        check("R5/R6/R7/R8 status read", rd_data, exp);
        k++;
      end else begin
        check("R11 hold without read", rd_data, prev);
      end
      rd_en = 1'b0;
      prev = rd_data;
      cyc++;
    end
    check("R4 busy length", cyc, dur);
    array_data = 8'hA0 ^ {6'b0, op} ^ data;
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    check("R9 array data after done", rd_data, 8'hA0 ^ {6'b0, op} ^ data);
    prev = rd_data;
    array_data = ~array_data;
    step();
    check("R11 hold after done", rd_data, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 busy at reset", busy, 0);
    check("R1 rd_data at reset", rd_data, 0);
    for (int op = 0; op < 4; op++) begin
      for (int d = 0; d < 5; d++) begin
        logic [7:0] dv;
        dv = (d == 0) ? 8'h00 : (d == 1) ? 8'h80 : (d == 2) ? 8'h7F : (d == 3) ? 8'hFF : 8'h3C;
        run_op(2'(op), dv);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule